// File: doc/BRIEF.md
# SPI Master Interrupt Event Controller

This block produces the interrupt events of a single-channel SPI master. It owns the transmit and receive byte buffers that sit between the CPU and the serial shifter. The shifter is not part of the block. It appears only as a transfer strobe, which takes one byte from the transmit side and delivers one received byte in the same cycle. Four events are tracked: transmit empty, transmit underflow, receive full and end of word count. Each event latches a sticky status bit, and software clears it by writing one to that bit. A per-event enable mask gates the status bits onto one registered interrupt line.

One 32-byte FIFO can be given to either direction. The direction that does not own it falls back to a one-entry holding register. When the FIFO is requested for both directions at once, neither direction gets it, and both sides run as single registers.

In FIFO mode, the threshold events re-arm only after the CPU has made exactly the programmed number of accesses. A nonzero word count halts the channel once that many transfers are done.

The data paths use valid/ready:
- The transmit side accepts a byte only when `tx_ready` is high.
- `tx_ready` is low while the channel is disabled, while it is in receive-only mode, or while the active buffer is full.
- The receive side holds `rx_valid` and `rx_data` steady until `rx_ready` takes the byte.
- A received byte that arrives while the receive buffer is full is dropped.

Top module: `spi_evt_ctrl`

## Requirements
- R1: After reset, the status and interrupt-enable registers read zero, `irq` is low, `tx_ready` is low and `rx_valid` is low.
- R2: The rising edge of control bit 0 (channel enable) sets status bit 0 (transmit empty) one clock edge later. This does not happen when control bit 1 (receive-only) is set.
- R3: When the transmit side owns the FIFO, status bit 0 sets while the free space is at least the almost-empty level. After it sets, it cannot set again until exactly that many bytes have been accepted on the transmit port.
- R4: Status bit 1 (underflow) sets when a strobe occurs on an enabled, non-halted, transmit-capable channel whose transmit buffer is empty. It never sets before the first byte has been accepted after the channel enable rose. A strobe with data available presents that byte on `shift_tx_data` with `shift_tx_valid` high.
- R5: Without the receive FIFO, status bit 2 (receive full) sets one edge after the receive register fills. After it sets, it re-arms after one read.
- R6: When the receive side owns the FIFO, status bit 2 sets while at least the almost-full level of bytes are held. After it sets, it re-arms only after exactly that many reads. Reads return bytes in arrival order.
- R7: When a direction owns the FIFO and the word-count register is nonzero, the strobe that completes that count sets status bit 3 and halts the channel. While halted, strobes neither pop nor push. A word count of zero never sets bit 3.
- R8: A halted channel resumes only after the word-count register has been written and the channel enable has risen again. A new enable rise alone keeps it halted.
- R9: When control bits 2 (transmit FIFO request) and 3 (receive FIFO request) are both set, both directions hold a single byte, so `tx_ready` falls after one accepted byte.
- R10: Status bits are sticky. Writing one to a bit at address 3 clears it, and writing zero leaves it unchanged.
- R11: `irq` goes high one edge after any status bit with its enable bit set (address 4) is high, and goes low one edge after none is.
- R12: The register map is: address 0 control [3:0]; address 1 levels, with the almost-empty level in [5:0] and the almost-full level in [13:8], where a value of 0 acts as 1; address 2 word count [15:0]; address 3 status; address 4 interrupt enable [3:0]. Each register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be accepted |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Oldest received byte |
| xfer_strobe | input | 1 | Shift-register load / transfer strobe |
| xfer_rx_data | input | 8 | Byte received by the shifter with this strobe |
| shift_tx_valid | output | 1 | A byte is handed to the shifter on this strobe |
| shift_tx_data | output | 8 | Byte handed to the shifter |
| irq | output | 1 | Registered interrupt line |

## Verification
Underflow and end-of-count latch on the same edge that samples the strobe, so the bench reads them at the first falling edge after the strobe. Transmit-empty and receive-full are evaluated from registered buffer state, so they latch one edge after the write, read, push or enable that caused them. The bench therefore waits exactly one more cycle before reading them, and also reads them one cycle early where that timing matters. `irq` follows status by one further edge, and the bench checks it both low and then high across that edge. `shift_tx_valid` and `shift_tx_data` are combinational in the strobe cycle, so they are sampled just after the strobe is driven.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int NEV    = 4;
  localparam int EV_TXE = 0;
  localparam int EV_TXU = 1;
  localparam int EV_RXF = 2;
  localparam int EV_EOW = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LEVEL = 3'd1;
  localparam logic [2:0] A_WCNT  = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_IRQEN = 3'd4;

  typedef struct packed {
    logic fifo_rx;
    logic fifo_tx;
    logic rx_only;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spi_evt_buf.sv
module spi_evt_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          room
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign room    = cnt_q < cap;
  assign do_push = push && room;
  assign do_pop  = pop && (cnt_q != '0);
  assign head    = mem[rd_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spi_evt_rearm.sv
module spi_evt_rearm #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic          level_ok,
  input  logic [CW-1:0] thr,
  input  logic          access,
  output logic          fire
);
  logic          armed_q, b_arm;
  logic [CW-1:0] cnt_q, b_cnt;

  assign fire  = active && (armed_q || start) && level_ok;
  assign b_arm = fire ? 1'b0 : (start ? 1'b1 : armed_q);
  assign b_cnt = (fire || start) ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!b_arm && access) begin
      if (b_cnt + 1'b1 >= thr) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        armed_q <= 1'b0;
        cnt_q   <= b_cnt + 1'b1;
      end
    end else begin
      armed_q <= b_arm;
      cnt_q   <= b_cnt;
    end
  end
endmodule

// File: rtl/spi_evt_wcnt.sv
module spi_evt_wcnt #(
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_rise,
  input  logic           step,
  input  logic           count_on,
  input  logic [WCW-1:0] limit,
  input  logic           limit_wr,
  output logic           halted,
  output logic           fire
);
  logic [WCW-1:0] cnt_q;
  logic           halt_q, reload_q;

  assign halted = halt_q;
  assign fire   = step && count_on && (WCW'(cnt_q + 1'b1) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      halt_q   <= 1'b0;
      reload_q <= 1'b0;
    end else if (fire) begin
      cnt_q    <= '0;
      halt_q   <= 1'b1;
      reload_q <= limit_wr;
    end else if (en_rise && (!halt_q || reload_q)) begin
      cnt_q    <= '0;
      halt_q   <= 1'b0;
      reload_q <= limit_wr;
    end else begin
      if (step && count_on) cnt_q <= cnt_q + 1'b1;
      if (limit_wr) reload_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int RW    = 16,
  parameter int WCW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          xfer_strobe,
  input  logic [DW-1:0] xfer_rx_data,
  output logic          shift_tx_valid,
  output logic [DW-1:0] shift_tx_data,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LVL_HI = 8;
  localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE  = CW'(1);

  ctrl_t          ctrl_q;
  logic [CW-1:0]  ael_q, afl_q;
  logic [WCW-1:0] wcnt_q;
  logic [NEV-1:0] stat_q, irqen_q, ev_set, stat_clr;
  logic           irq_q, en_prev_q, loaded_q;

  logic en, en_rise, tx_own, rx_own, fifo_mode, halted, live, xfer;
  logic tx_side, tx_room, rx_room, tx_acc, rx_acc, tx_pop, rx_push;
  logic [CW-1:0] tx_cap, rx_cap, tx_cnt, rx_cnt, tx_free, thr_tx, thr_rx;
  logic [DW-1:0] tx_head, rx_head;
  logic txe_fire, txu_fire, rxf_fire, eow_fire;
  logic wr_ctrl, wr_level, wr_wcnt, wr_stat, wr_irqen;

  function automatic logic [CW-1:0] lvl_fix(input logic [CW-1:0] v);
    if (v == '0) return CAP_ONE;
    if (v > CAP_FULL) return CAP_FULL;
    return v;
  endfunction

  // register decode
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_level = reg_wr && (reg_addr == A_LEVEL);
  assign wr_wcnt  = reg_wr && (reg_addr == A_WCNT);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign wr_irqen = reg_wr && (reg_addr == A_IRQEN);
  assign stat_clr = wr_stat ? reg_wdata[NEV-1:0] : '0;

  // mode and FIFO ownership
  assign en        = ctrl_q.en;
  assign en_rise   = en && !en_prev_q;
  assign tx_own    = ctrl_q.fifo_tx && !ctrl_q.fifo_rx;
  assign rx_own    = ctrl_q.fifo_rx && !ctrl_q.fifo_tx;
  assign fifo_mode = tx_own || rx_own;
  assign tx_cap    = tx_own ? CAP_FULL : CAP_ONE;
  assign rx_cap    = rx_own ? CAP_FULL : CAP_ONE;
  assign thr_tx    = tx_own ? lvl_fix(ael_q) : CAP_ONE;
  assign thr_rx    = rx_own ? lvl_fix(afl_q) : CAP_ONE;

  // data paths
  assign live     = en && !halted;
  assign xfer     = xfer_strobe && live;
  assign tx_side  = en && !ctrl_q.rx_only;
  assign tx_ready = tx_side && tx_room;
  assign tx_acc   = tx_valid && tx_ready;
  assign tx_pop   = xfer && !ctrl_q.rx_only && (tx_cnt != '0);
  assign rx_push  = xfer && rx_room;
  assign rx_valid = rx_cnt != '0;
  assign rx_acc   = rx_valid && rx_ready;
  assign rx_data  = rx_head;
  assign tx_free  = tx_room ? tx_cap - tx_cnt : '0;
  assign shift_tx_valid = tx_pop;
  assign shift_tx_data  = tx_head;

  spi_evt_buf #(.DEPTH(DEPTH), .DW(DW)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .cap(tx_cap), .push(tx_acc), .push_data(tx_data),
    .pop(tx_pop), .head(tx_head), .count(tx_cnt), .room(tx_room)
  );

  spi_evt_buf #(.DEPTH(DEPTH), .DW(DW)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .cap(rx_cap), .push(rx_push), .push_data(xfer_rx_data),
    .pop(rx_acc), .head(rx_head), .count(rx_cnt), .room(rx_room)
  );

  // threshold events
  spi_evt_rearm #(.CW(CW)) u_txe (
    .clk(clk), .rst_n(rst_n), .start(en_rise), .active(tx_side),
    .level_ok(tx_free >= thr_tx), .thr(thr_tx), .access(tx_acc), .fire(txe_fire)
  );

  spi_evt_rearm #(.CW(CW)) u_rxf (
    .clk(clk), .rst_n(rst_n), .start(en_rise), .active(en),
    .level_ok(rx_cnt >= thr_rx), .thr(thr_rx), .access(rx_acc), .fire(rxf_fire)
  );

  spi_evt_wcnt #(.WCW(WCW)) u_wcnt (
    .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .step(xfer),
    .count_on(fifo_mode && (wcnt_q != '0)), .limit(wcnt_q), .limit_wr(wr_wcnt),
    .halted(halted), .fire(eow_fire)
  );

  assign txu_fire = xfer && !ctrl_q.rx_only && (tx_cnt == '0) && loaded_q && !en_rise;

  assign ev_set[EV_TXE] = txe_fire;
  assign ev_set[EV_TXU] = txu_fire;
  assign ev_set[EV_RXF] = rxf_fire;
  assign ev_set[EV_EOW] = eow_fire;

  // sticky status bits, set has priority over clear
  for (genvar i = 0; i < NEV; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= ev_set[i] || (stat_q[i] && !stat_clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ael_q     <= '0;
      afl_q     <= '0;
      wcnt_q    <= '0;
      irqen_q   <= '0;
      irq_q     <= 1'b0;
      en_prev_q <= 1'b0;
      loaded_q  <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(reg_wdata[3:0]);
      if (wr_level) begin
        ael_q <= reg_wdata[CW-1:0];
        afl_q <= reg_wdata[LVL_HI +: CW];
      end
      if (wr_wcnt)  wcnt_q  <= reg_wdata[WCW-1:0];
      if (wr_irqen) irqen_q <= reg_wdata[NEV-1:0];
      irq_q     <= |(stat_q & irqen_q);
      en_prev_q <= en;
      if (en_rise)     loaded_q <= tx_acc;
      else if (tx_acc) loaded_q <= 1'b1;
    end
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[3:0] = ctrl_q;
      A_LEVEL: begin
        reg_rdata[CW-1:0]      = ael_q;
        reg_rdata[LVL_HI +: CW] = afl_q;
      end
      A_WCNT:  reg_rdata[WCW-1:0] = wcnt_q;
      A_STAT:  reg_rdata[NEV-1:0] = stat_q;
      A_IRQEN: reg_rdata[NEV-1:0] = irqen_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_evt_ctrl_chk.sv
module spi_evt_ctrl_chk #(
  parameter int NEV = 4,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [NEV-1:0] stat,
  input logic [NEV-1:0] irqen,
  input logic [NEV-1:0] clr,
  input logic           irq,
  input logic           halted,
  input logic           rx_valid,
  input logic           rx_ready,
  input logic [DW-1:0]  rx_data
);
  logic en_d, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      en_d <= en;
      if (en && !en_d)              seen_q <= tx_valid && tx_ready;
      else if (tx_valid && tx_ready) seen_q <= 1'b1;
    end
  end

  a_r11_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & irqen)) |=> irq);

  a_r11_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & irqen)) |=> !irq);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr)));

  a_r4_no_early_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !stat[1]) |=> !stat[1]);

  a_r7_eow_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[3]) |-> halted);

  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_evt_ctrl spi_evt_ctrl_chk #(.NEV(spi_evt_pkg::NEV), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .stat(stat_q), .irqen(irqen_q), .clr(stat_clr), .irq(irq), .halted(halted),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/spi_evt_ctrl_tb.sv
module spi_evt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = 8'd0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        xfer_strobe = 1'b0;
  logic [7:0]  xfer_rx_data = 8'd0;
  logic        shift_tx_valid;
  logic [7:0]  shift_tx_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  spi_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .xfer_strobe(xfer_strobe),
    .xfer_rx_data(xfer_rx_data), .shift_tx_valid(shift_tx_valid),
    .shift_tx_data(shift_tx_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic stat_bit(input int b, output logic v);
    logic [15:0] d;
    rd(3'd3, d);
    v = d[b];
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] b, output logic sv, output logic [7:0] sd);
    @(negedge clk);
    xfer_strobe = 1'b1; xfer_rx_data = b;
    #1 sv = shift_tx_valid; sd = shift_tx_data;
    @(negedge clk);
    xfer_strobe = 1'b0;
  endtask

  task automatic pop_rx(output logic v, output logic [7:0] d);
    @(negedge clk);
    rx_ready = 1'b1;
    #1 v = rx_valid; d = rx_data;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic restart(input logic [15:0] c);
    wr(3'd0, 16'd0);
    wr(3'd0, c);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd3, d); chk("R1 status zero", d, 0);
    rd(3'd4, d); chk("R1 irq enable zero", d, 0);
    chk("R1 irq low", irq, 0);
    chk("R1 tx_ready low", tx_ready, 0);
    chk("R1 rx_valid low", rx_valid, 0);
  endtask

  task automatic t_enable();
    logic v; logic [15:0] d;
    wr(3'd4, 16'h1);
    wr(3'd0, 16'h1);
    tick(1);
    stat_bit(0, v); chk("R2 txe on enable", v, 1);
    chk("R11 irq not yet", irq, 0);
    tick(1);
    chk("R11 irq one edge after status", irq, 1);
    wr(3'd3, 16'h2);
    stat_bit(0, v); chk("R10 zero write keeps bit", v, 1);
    wr(3'd3, 16'h1);
    stat_bit(0, v); chk("R10 w1c clears", v, 0);
    tick(1);
    chk("R11 irq falls", irq, 0);
    wr(3'd0, 16'h0);
    wr(3'd3, 16'hF);
    wr(3'd0, 16'h3);
    tick(2);
    stat_bit(0, v); chk("R2 no txe in receive-only", v, 0);
    wr(3'd1, 16'h0403);
    rd(3'd1, d); chk("R12 level readback", d, 16'h0403);
    wr(3'd2, 16'h1234);
    rd(3'd2, d); chk("R12 wcnt readback", d, 16'h1234);
    wr(3'd2, 16'h0);
    rd(3'd0, d); chk("R12 ctrl readback", d, 16'h3);
  endtask

  task automatic t_underflow();
    logic v, sv; logic [7:0] sd, rd8;
    restart(16'h1);
    wr(3'd3, 16'hF);
    strobe(8'h00, sv, sd);
    stat_bit(1, v); chk("R4 no underflow before first write", v, 0);
    push(8'h3C);
    strobe(8'h00, sv, sd);
    chk("R4 shift valid", sv, 1);
    chk("R4 shift data", sd, 8'h3C);
    stat_bit(1, v); chk("R4 no underflow with data", v, 0);
    strobe(8'h00, sv, sd);
    stat_bit(1, v); chk("R4 underflow on empty load", v, 1);
    pop_rx(v, rd8);
  endtask

  task automatic t_force();
    logic v, sv; logic [7:0] sd, d8;
    restart(16'hD);
    wr(3'd3, 16'hF);
    chk("R9 ready before byte", tx_ready, 1);
    push(8'h11);
    chk("R9 ready drops after one byte", tx_ready, 0);
    strobe(8'h77, sv, sd);
    chk("R9 byte shifted", sd, 8'h11);
    pop_rx(v, d8);
    chk("R9 rx byte", d8, 8'h77);
  endtask

  task automatic t_rx_single();
    logic v, sv; logic [7:0] sd, d8;
    restart(16'h1);
    wr(3'd3, 16'hF);
    strobe(8'hA5, sv, sd);
    stat_bit(2, v); chk("R5 rxf not before one edge", v, 0);
    tick(1);
    stat_bit(2, v); chk("R5 rxf set", v, 1);
    chk("R5 rx_valid", rx_valid, 1);
    chk("R5 rx_data", rx_data, 8'hA5);
    wr(3'd3, 16'h4);
    tick(1);
    stat_bit(2, v); chk("R5 no refire while unread", v, 0);
    pop_rx(v, d8);
    strobe(8'h5A, sv, sd);
    tick(1);
    stat_bit(2, v); chk("R5 rearmed after one read", v, 1);
    pop_rx(v, d8);
    chk("R5 second byte", d8, 8'h5A);
  endtask

  task automatic t_rx_fifo();
    logic v, sv; logic [7:0] sd, d8;
    wr(3'd0, 16'h0);
    wr(3'd1, 16'h0408);
    wr(3'd0, 16'h9);
    wr(3'd3, 16'hF);
    for (int i = 0; i < 3; i++) strobe(8'h10 + 8'(i), sv, sd);
    tick(1);
    stat_bit(2, v); chk("R6 below afl", v, 0);
    strobe(8'h13, sv, sd);
    tick(1);
    stat_bit(2, v); chk("R6 at afl", v, 1);
    wr(3'd3, 16'h4);
    for (int i = 4; i < 8; i++) strobe(8'h10 + 8'(i), sv, sd);
    tick(1);
    stat_bit(2, v); chk("R6 disarmed despite level", v, 0);
    pop_rx(v, d8);
    chk("R6 fifo order", d8, 8'h10);
    pop_rx(v, d8);
    pop_rx(v, d8);
    tick(1);
    stat_bit(2, v); chk("R6 three reads not enough", v, 0);
    pop_rx(v, d8);
    chk("R6 fourth byte", d8, 8'h13);
    tick(1);
    stat_bit(2, v); chk("R6 rearmed after afl reads", v, 1);
    stat_bit(3, v); chk("R7 zero wcnt no eow", v, 0);
    for (int i = 0; i < 4; i++) pop_rx(v, d8);
  endtask

  task automatic t_tx_fifo();
    logic v;
    restart(16'h5);
    tick(1);
    stat_bit(0, v); chk("R3 txe with free space", v, 1);
    wr(3'd3, 16'hF);
    for (int i = 0; i < 7; i++) push(8'h40 + 8'(i));
    tick(1);
    stat_bit(0, v); chk("R3 no txe before ael writes", v, 0);
    push(8'h47);
    tick(1);
    stat_bit(0, v); chk("R3 txe after ael writes", v, 1);
  endtask

  task automatic t_eow();
    logic v, sv; logic [7:0] sd;
    wr(3'd0, 16'h0);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h5);
    wr(3'd3, 16'hF);
    strobe(8'h0, sv, sd);
    strobe(8'h0, sv, sd);
    stat_bit(3, v); chk("R7 no eow before count", v, 0);
    strobe(8'h0, sv, sd);
    chk("R7 last transfer shifts", sv, 1);
    stat_bit(3, v); chk("R7 eow at count", v, 1);
    strobe(8'h0, sv, sd);
    chk("R7 halted no shift", sv, 0);
    restart(16'h5);
    strobe(8'h0, sv, sd);
    chk("R8 enable alone stays halted", sv, 0);
    wr(3'd2, 16'd3);
    restart(16'h5);
    strobe(8'h0, sv, sd);
    chk("R8 resumes after reload and enable", sv, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_enable();
    t_underflow();
    t_force();
    t_rx_single();
    t_rx_fifo();
    t_tx_fifo();
    t_eow();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule